// File: doc/BRIEF.md
# Load-Use Hazard Stall Unit

This block is the hazard detection logic of a five-stage in-order pipeline. During decode it compares the source register numbers of the instruction held in the fetch/decode pipeline register against the destination of the instruction one stage ahead. That instruction sits in the decode/execute register. If the instruction ahead is a load, its data exists only at the end of its memory stage. The dependent instruction directly behind it would need that value at the start of the same cycle, so forwarding alone cannot supply it.

When such a dependency is found, the unit inserts one bubble. It holds the program counter and the fetch/decode register, and it clears the control bits that enter the decode/execute register so that the slot becomes a no-op. One cycle later the load has moved on to its memory stage and the bubble sits between producer and consumer. The stall then releases by itself, and the consumer picks up the loaded value through forwarding from the memory/writeback register. Without that forwarding path, the same dependency would need a two-cycle wait for writeback.

The unit is purely combinational. The pipeline registers, the forwarding multiplexers, the memories and branch hazards all lie outside it.

Top module: `ldu_stall_unit`

## Requirements
- R1: The stall is raised when the instruction in execute is a load (`ex_is_load_i`=1), its destination is nonzero, and the destination equals the first decode source `dec_src_a_i`.
- R2: The stall is raised under the same load and nonzero conditions when the destination equals the second decode source `dec_src_b_i`.
- R3: A load whose destination is register 0 never raises the stall, even if a decode source is also 0, because register 0 is hardwired to zero.
- R4: When `ex_is_load_i`=0, no stall is raised, whatever the register numbers are.
- R5: The three control outputs always move together. When stalling, `pc_we_o`=0, `dec_we_o`=0 and `ex_flush_o`=1. Otherwise `pc_we_o`=1, `dec_we_o`=1 and `ex_flush_o`=0.
- R6: In a pipeline built around the unit, a load followed directly by a dependent instruction stalls for exactly one cycle. During that cycle a no-op enters execute, and the dependent instruction enters execute on the following cycle with no further stall.
- R7: In the same pipeline, an instruction after a load that reads neither source equal to the load destination causes no stall.
- R8: When both decode sources equal the load destination, the unit still inserts a single one-cycle bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_is_load_i | input | 1 | Memory-read flag of the instruction in the decode/execute register |
| ex_dst_i | input | REG_W | Destination register number of the instruction in execute |
| dec_src_a_i | input | REG_W | First source register number of the instruction in decode |
| dec_src_b_i | input | REG_W | Second source register number of the instruction in decode |
| pc_we_o | output | 1 | Program counter write enable, low while stalling |
| dec_we_o | output | 1 | Fetch/decode register write enable, low while stalling |
| ex_flush_o | output | 1 | Clears the control bits entering decode/execute, forming a no-op |

## Verification
The two source comparators can both hit in the same cycle. The bench provokes this with an instruction that reads the loaded register through both operands. It then judges that the outputs still show one bubble lasting a single cycle. The second overlap is between the stall release and the next fetch: the cycle after the bubble must fetch normally while the held dependent instruction advances. This is judged by following where the instruction stream sits in a small pipeline model kept in the bench.

// File: rtl/ldu_pkg.sv
package ldu_pkg;

  // Returns 1 when a load writing dst feeds the source register src.
  function automatic logic load_feeds(
    input logic        is_load,
    input logic [31:0] dst,
    input logic [31:0] src,
    input logic        zero_hardwired
  );
    logic same;
    logic dst_live;
    same     = (dst == src);
    dst_live = zero_hardwired ? (dst != 32'd0) : 1'b1;
    return is_load && same && dst_live;
  endfunction

  typedef struct packed {
    logic pc_we;
    logic dec_we;
    logic flush;
  } stall_ctl_t;

endpackage

// File: rtl/ldu_src_cmp.sv
module ldu_src_cmp #(
  parameter int REG_W          = 5,
  parameter bit ZERO_HARDWIRED = 1'b1
) (
  input  logic             is_load,
  input  logic [REG_W-1:0] dst,
  input  logic [REG_W-1:0] src,
  output logic             hit
);
  import ldu_pkg::*;

  always_comb begin
    hit = load_feeds(is_load, 32'(dst), 32'(src), ZERO_HARDWIRED);
  end

  always_comb begin
    if (!$isunknown({is_load, dst, src, hit})) begin
      // R3
      no_zero_dst_hit_chk: assert (!(hit && ZERO_HARDWIRED && dst == '0))
        else $error("hit on register zero");
      // R4
      no_hit_without_load_chk: assert (!(hit && !is_load))
        else $error("hit without a load");
    end
  end

endmodule

// File: rtl/ldu_stall_ctl.sv
module ldu_stall_ctl #(
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0] hits,
  output ldu_pkg::stall_ctl_t ctl
);
  logic stall_req;

  always_comb begin
    stall_req  = |hits;
    ctl.pc_we  = ~stall_req;
    ctl.dec_we = ~stall_req;
    ctl.flush  = stall_req;
  end

endmodule

// File: rtl/ldu_stall_unit.sv
module ldu_stall_unit #(
  parameter int REG_W          = 5,
  parameter bit ZERO_HARDWIRED = 1'b1
) (
  input  logic             ex_is_load_i,
  input  logic [REG_W-1:0] ex_dst_i,
  input  logic [REG_W-1:0] dec_src_a_i,
  input  logic [REG_W-1:0] dec_src_b_i,
  output logic             pc_we_o,
  output logic             dec_we_o,
  output logic             ex_flush_o
);
  localparam int NUM_SRC = 2;

  logic [REG_W-1:0]   src_vec [NUM_SRC];
  logic [NUM_SRC-1:0] src_hit;
  ldu_pkg::stall_ctl_t ctl;

  assign src_vec[0] = dec_src_a_i;
  assign src_vec[1] = dec_src_b_i;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cmp
    ldu_src_cmp #(
      .REG_W          (REG_W),
      .ZERO_HARDWIRED (ZERO_HARDWIRED)
    ) u_cmp (
      .is_load (ex_is_load_i),
      .dst     (ex_dst_i),
      .src     (src_vec[g]),
      .hit     (src_hit[g])
    );
  end

  ldu_stall_ctl #(.NUM_SRC(NUM_SRC)) u_ctl (
    .hits (src_hit),
    .ctl  (ctl)
  );

  assign pc_we_o    = ctl.pc_we;
  assign dec_we_o   = ctl.dec_we;
  assign ex_flush_o = ctl.flush;

  always_comb begin
    if (!$isunknown({src_hit, pc_we_o, dec_we_o, ex_flush_o})) begin
      // R1
      src_a_flush_chk: assert (!src_hit[0] || ex_flush_o)
        else $error("first source hit without flush");
      // R2
      src_b_flush_chk: assert (!src_hit[1] || ex_flush_o)
        else $error("second source hit without flush");
      // R5
      hold_when_flush_chk: assert (!ex_flush_o || (!pc_we_o && !dec_we_o))
        else $error("flush while writes enabled");
      // R5
      flush_needs_hit_chk: assert (ex_flush_o == (|src_hit))
        else $error("flush not matched to a hit");
    end
  end

endmodule

// File: tb/sim_ldu_stall_unit.sv
module sim_ldu_stall_unit;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 5;

  typedef struct packed {
    logic          ld;
    logic [RW-1:0] dst;
    logic [RW-1:0] sa;
    logic [RW-1:0] sb;
    logic [7:0]    tag;
  } ins_t;

  localparam ins_t NOP = '{ld:1'b0, dst:'0, sa:'0, sb:'0, tag:8'd0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  int checks = 0;
  int fails = 0;

  logic          pipe_mode = 1'b0;
  logic          d_ld;
  logic [RW-1:0] d_dst, d_sa, d_sb;
  ins_t prog [16];
  int   pc;
  ins_t ifid, idex;

  logic          i_ld;
  logic [RW-1:0] i_dst, i_sa, i_sb;
  logic pc_we, dec_we, flush;

  assign i_ld  = pipe_mode ? idex.ld  : d_ld;
  assign i_dst = pipe_mode ? idex.dst : d_dst;
  assign i_sa  = pipe_mode ? ifid.sa  : d_sa;
  assign i_sb  = pipe_mode ? ifid.sb  : d_sb;

  ldu_stall_unit #(.REG_W(RW)) u0 (
    .ex_is_load_i (i_ld),
    .ex_dst_i     (i_dst),
    .dec_src_a_i  (i_sa),
    .dec_src_b_i  (i_sb),
    .pc_we_o      (pc_we),
    .dec_we_o     (dec_we),
    .ex_flush_o   (flush)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Pipeline model around the unit
  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= 0; ifid <= NOP; idex <= NOP;
    end else begin
      if (pc_we) pc <= pc + 1;
      if (dec_we) ifid <= prog[pc];
      idex <= flush ? NOP : ifid;
    end
  end

  function automatic logic want_stall(logic ld, logic [RW-1:0] dst,
                                      logic [RW-1:0] a, logic [RW-1:0] b);
    return ld & (|dst) & (~|(dst ^ a) | ~|(dst ^ b));
  endfunction

  task automatic chk(string req, logic [2:0] got, logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got pc_we/dec_we/flush=%b expected %b", req, got, exp);
    end
  endtask

  task automatic chk_int(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic apply(string req, logic ld, logic [RW-1:0] dst,
                       logic [RW-1:0] a, logic [RW-1:0] b);
    logic s;
    d_ld = ld; d_dst = dst; d_sa = a; d_sb = b;
    #1;
    s = want_stall(ld, dst, a, b);
    chk(req, {pc_we, dec_we, flush}, {~s, ~s, s});
  endtask

  task automatic t_idle();
    apply("R5 idle", 1'b0, '0, '0, '0);
  endtask

  task automatic t_direct();
    apply("R1 src a hit", 1'b1, 5'd2, 5'd2, 5'd5);
    chk("R1 stall value", {pc_we, dec_we, flush}, 3'b001);
    apply("R2 src b hit", 1'b1, 5'd7, 5'd6, 5'd7);
    chk("R2 stall value", {pc_we, dec_we, flush}, 3'b001);
    apply("R3 zero dst", 1'b1, 5'd0, 5'd0, 5'd0);
    chk("R3 no stall", {pc_we, dec_we, flush}, 3'b110);
    apply("R4 no load", 1'b0, 5'd9, 5'd9, 5'd9);
    chk("R4 no stall", {pc_we, dec_we, flush}, 3'b110);
    apply("R5 top reg", 1'b1, 5'd31, 5'd1, 5'd31);
    apply("R7 distinct", 1'b1, 5'd3, 5'd4, 5'd30);
  endtask

  // Runs prog through the pipe model and records stalls and entry cycles.
  task automatic run_pipe(output int stalls, output int first_stall,
                          output int dep_ex_cycle, input logic [7:0] dep_tag,
                          output int bubble_after);
    stalls = 0; first_stall = -1; dep_ex_cycle = -1; bubble_after = 0;
    pipe_mode = 1'b1;
    rst = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); rst = 1'b0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      if (flush) begin
        stalls++;
        if (first_stall < 0) first_stall = c;
      end
      if (idex.tag == dep_tag && dep_ex_cycle < 0) dep_ex_cycle = c;
      if (first_stall >= 0 && c == first_stall + 1 && idex.tag == 8'd0) bubble_after = 1;
    end
    pipe_mode = 1'b0;
  endtask

  task automatic t_pipe_dep();
    int st, fs, dc, bu;
    for (int k = 0; k < 16; k++) prog[k] = NOP;
    prog[0] = '{ld:1'b1, dst:5'd2, sa:5'd3, sb:5'd0, tag:8'd1};
    prog[1] = '{ld:1'b0, dst:5'd12, sa:5'd2, sb:5'd5, tag:8'd2};
    prog[2] = '{ld:1'b0, dst:5'd13, sa:5'd6, sb:5'd2, tag:8'd3};
    run_pipe(st, fs, dc, 8'd2, bu);
    chk_int("R6 stall count", st, 1);
    chk_int("R6 bubble enters execute", bu, 1);
    chk_int("R6 dependent enters execute after bubble", dc, fs + 2);
  endtask

  task automatic t_pipe_indep();
    int st, fs, dc, bu;
    for (int k = 0; k < 16; k++) prog[k] = NOP;
    prog[0] = '{ld:1'b1, dst:5'd2, sa:5'd3, sb:5'd0, tag:8'd1};
    prog[1] = '{ld:1'b0, dst:5'd12, sa:5'd4, sb:5'd5, tag:8'd2};
    prog[2] = '{ld:1'b1, dst:5'd0, sa:5'd1, sb:5'd0, tag:8'd3};
    prog[3] = '{ld:1'b0, dst:5'd8, sa:5'd0, sb:5'd0, tag:8'd4};
    run_pipe(st, fs, dc, 8'd2, bu);
    chk_int("R7 independent and zero-dst loads stall count", st, 0);
  endtask

  task automatic t_pipe_both();
    int st, fs, dc, bu;
    for (int k = 0; k < 16; k++) prog[k] = NOP;
    prog[0] = '{ld:1'b1, dst:5'd9, sa:5'd3, sb:5'd0, tag:8'd1};
    prog[1] = '{ld:1'b0, dst:5'd10, sa:5'd9, sb:5'd9, tag:8'd2};
    run_pipe(st, fs, dc, 8'd2, bu);
    chk_int("R8 both sources stall count", st, 1);
    chk_int("R8 dependent delayed one cycle", dc, fs + 2);
  endtask

  initial begin
    d_ld = 1'b0; d_dst = '0; d_sa = '0; d_sb = '0;
    for (int k = 0; k < 16; k++) prog[k] = NOP;
    #(CLK_PERIOD/2 + 1);
    t_idle();
    t_direct();
    t_pipe_dep();
    t_pipe_indep();
    t_pipe_both();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule